// File: doc/BRIEF.md
# Memory Region Protection Classifier

This unit sits between a processor's load/store path and the memory side. Every request carries an address, a store flag and an instruction-fetch flag. The unit compares the address against a small table of programmable address windows, and each window holds a protection class. From the class it works out four things: whether the access is legal, whether integrity checking is needed, whether encryption or decryption is needed, and whether a fetched instruction belongs to the program's authenticated code image. Requests that need a service go to the protection engines. All other requests go straight to memory.

There are five classes. Two are read-only (static) and two are read-write (dynamic); each of these pairs has a check-only level and a check-plus-cipher level. The fifth class is open memory, which gets no service at all. Any address that falls outside every window is open memory. The window table is written through a one-cycle configuration port. Results come out registered, one clock after the request.

Top module: `mem_prot_classifier`

## Requirements
- R1: A request presented with `req_valid` high yields `rsp_valid` high exactly one clock later, together with its address and store flag. `rsp_valid` is low in every other cycle. During reset every output is low.
- R2: A window hits when `win_base <= address <= win_limit`, with both bounds inclusive. A window with base greater than limit never hits. After reset every window has base all-ones and limit zero, so all addresses are open.
- R3: When several windows hit, the one with the lowest index supplies the class.
- R4: An address that hits no window, or whose selected window holds class code 0 (open), gives `need_verify`, `need_crypt`, `to_engine` and `fault` all low.
- R5: The class codes are: 1 = static checked, 2 = static ciphered, 3 = dynamic checked, 4 = dynamic ciphered. Codes 1 to 4 set `need_verify` on a legal access. Codes 2 and 4 also set `need_crypt`. `need_crypt` is never high without `need_verify`.
- R6: A store whose selected class is 1 or 2 raises `fault`. A faulted response has `need_verify`, `need_crypt`, `to_engine` and `code_ident` all low.
- R7: Codes 5, 6 and 7 are illegal. Any access (load, store or fetch) that selects such a window raises `fault`.
- R8: `code_ident` is high only for a non-store instruction fetch that selects class 1 to 4 without a fault.
- R9: `to_engine` equals `need_verify` on every valid response. It is high exactly when the access is sent to the protection engines instead of going directly to memory.
- R10: A configuration write (`cfg_we`, `cfg_idx`, base, limit, class) takes effect for requests sampled from the next clock on. A request sampled in the same clock as the write still sees the old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window table write strobe |
| cfg_idx | input | 2 | Window index to write |
| cfg_base | input | 32 | Lower bound (inclusive) |
| cfg_limit | input | 32 | Upper bound (inclusive) |
| cfg_class | input | 3 | Class code of the window |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a store |
| req_fetch | input | 1 | Request is an instruction fetch |
| rsp_valid | output | 1 | Registered result valid |
| rsp_addr | output | 32 | Address of the result |
| rsp_write | output | 1 | Store flag of the result |
| need_verify | output | 1 | Integrity check required |
| need_crypt | output | 1 | Encryption/decryption required |
| to_engine | output | 1 | Route to protection engines |
| fault | output | 1 | Protection fault |
| code_ident | output | 1 | Fetch belongs to the authenticated code image |

## Verification
Two cases are hard to reach from the ports. The first is a priority conflict, which needs two overlapping windows programmed with different classes and then accesses on both sides of the overlap edge. The second is the write-versus-lookup race of R10, which needs a configuration write and a request in the same clock. The stimulus programs overlapping windows so that a static checked window shadows a dynamic ciphered one. It then walks base, limit and limit+1 of each window, and finally reprograms an illegal window in the same cycle as a fetch into it, and again one cycle before one.

// File: rtl/mem_prot_pkg.sv
package mem_prot_pkg;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_OPEN = 3'd0,
        CLS_SCHK = 3'd1,
        CLS_SCIP = 3'd2,
        CLS_DCHK = 3'd3,
        CLS_DCIP = 3'd4
    } prot_class_e;

    typedef struct packed {
        logic verify;
        logic crypt;
        logic fault;
        logic ident;
    } prot_decision_t;
endpackage

// File: rtl/prot_window_table.sv
module prot_window_table
    import mem_prot_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int AW      = 32,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [AW-1:0]            cfg_base,
    input  logic [AW-1:0]            cfg_limit,
    input  logic [CLS_W-1:0]         cfg_class,
    input  logic [AW-1:0]            look_addr,
    output logic [NUM_WIN-1:0]       hit_vec,
    output logic [NUM_WIN*CLS_W-1:0] cls_flat
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [AW-1:0]    base_q;
        logic [AW-1:0]    limit_q;
        logic [CLS_W-1:0] cls_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= '1;
                limit_q <= '0;
                cls_q   <= CLS_OPEN;
            end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                base_q  <= cfg_base;
                limit_q <= cfg_limit;
                cls_q   <= cfg_class;
            end
        end

        assign hit_vec[g] = (look_addr >= base_q) && (look_addr <= limit_q);
        assign cls_flat[g*CLS_W +: CLS_W] = cls_q;
    end
endmodule

// File: rtl/prot_priority_pick.sv
module prot_priority_pick
    import mem_prot_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic [NUM_WIN-1:0]       hit_vec,
    input  logic [NUM_WIN*CLS_W-1:0] cls_flat,
    output logic [CLS_W-1:0]         sel_class
);
    always_comb begin
        sel_class = CLS_OPEN;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_class = cls_flat[i*CLS_W +: CLS_W];
            end
        end
    end
endmodule

// File: rtl/prot_class_decode.sv
module prot_class_decode
    import mem_prot_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic             is_write,
    input  logic             is_fetch,
    output prot_decision_t   dec
);
    logic chk;
    logic cip;
    logic ro;
    logic bad;

    always_comb begin
        chk = 1'b0;
        cip = 1'b0;
        ro  = 1'b0;
        bad = 1'b0;
        unique case (cls)
            CLS_OPEN: ;
            CLS_SCHK: begin chk = 1'b1; ro = 1'b1; end
            CLS_SCIP: begin chk = 1'b1; cip = 1'b1; ro = 1'b1; end
            CLS_DCHK: chk = 1'b1;
            CLS_DCIP: begin chk = 1'b1; cip = 1'b1; end
            default:  bad = 1'b1;
        endcase

        dec.fault  = bad || (ro && is_write);
        dec.verify = chk && !dec.fault;
        dec.crypt  = cip && !dec.fault;
        dec.ident  = chk && is_fetch && !is_write && !dec.fault;
    end
endmodule

// File: rtl/mem_prot_classifier.sv
module mem_prot_classifier
    import mem_prot_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int AW      = 32,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_limit,
    input  logic [CLS_W-1:0] cfg_class,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic             req_fetch,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_addr,
    output logic             rsp_write,
    output logic             need_verify,
    output logic             need_crypt,
    output logic             to_engine,
    output logic             fault,
    output logic             code_ident
);
    logic [NUM_WIN-1:0]       hit_vec;
    logic [NUM_WIN*CLS_W-1:0] cls_flat;
    logic [CLS_W-1:0]         sel_class;
    prot_decision_t           dec;

    prot_window_table #(.NUM_WIN(NUM_WIN), .AW(AW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .cfg_class (cfg_class),
        .look_addr (req_addr),
        .hit_vec   (hit_vec),
        .cls_flat  (cls_flat)
    );

    prot_priority_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hit_vec   (hit_vec),
        .cls_flat  (cls_flat),
        .sel_class (sel_class)
    );

    prot_class_decode u_dec (
        .cls      (sel_class),
        .is_write (req_write),
        .is_fetch (req_fetch),
        .dec      (dec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_addr    <= '0;
            rsp_write   <= 1'b0;
            need_verify <= 1'b0;
            need_crypt  <= 1'b0;
            to_engine   <= 1'b0;
            fault       <= 1'b0;
            code_ident  <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_addr    <= req_valid ? req_addr : '0;
            rsp_write   <= req_valid && req_write;
            need_verify <= req_valid && dec.verify;
            need_crypt  <= req_valid && dec.crypt;
            to_engine   <= req_valid && dec.verify;
            fault       <= req_valid && dec.fault;
            code_ident  <= req_valid && dec.ident;
        end
    end
endmodule

// File: rtl/mem_prot_classifier_sva.sv
module mem_prot_classifier_sva (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_write,
    input logic req_fetch,
    input logic rsp_valid,
    input logic rsp_write,
    input logic need_verify,
    input logic need_crypt,
    input logic to_engine,
    input logic fault,
    input logic code_ident
);
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r5_crypt_needs_verify: assert property (@(posedge clk) disable iff (!rst_n)
        need_crypt |-> need_verify);
    a_r6_fault_blocks_service: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!need_verify && !need_crypt && !to_engine && !code_ident));
    a_r8_ident_only_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!code_ident || ($past(req_fetch) && !rsp_write)));
    a_r9_route_matches_verify: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (to_engine == need_verify));
    a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(need_verify || fault || code_ident || to_engine));
    a_r1_write_carried: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_write == $past(req_write)));
endmodule

bind mem_prot_classifier mem_prot_classifier_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_fetch   (req_fetch),
    .rsp_valid   (rsp_valid),
    .rsp_write   (rsp_write),
    .need_verify (need_verify),
    .need_crypt  (need_crypt),
    .to_engine   (to_engine),
    .fault       (fault),
    .code_ident  (code_ident)
);

// File: tb/mem_prot_classifier_bench.sv
module mem_prot_classifier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_limit = '0;
    logic [2:0]  cfg_class = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        rsp_valid, rsp_write, need_verify, need_crypt, to_engine, fault, code_ident;
    logic [31:0] rsp_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_prot_classifier u_mem_prot_classifier (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_class(cfg_class),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_fetch(req_fetch), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_write(rsp_write), .need_verify(need_verify), .need_crypt(need_crypt),
        .to_engine(to_engine), .fault(fault), .code_ident(code_ident)
    );

    typedef struct {
        logic [31:0] addr;
        logic [6:0]  flags; // write, verify, crypt, engine, fault, ident, spare
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] m_base[NW];
    logic [31:0] m_lim[NW];
    logic [2:0]  m_cls[NW];

    function automatic logic [6:0] model(logic [31:0] a, logic w, logic f);
        logic [2:0] c = 3'd0;
        logic chk, cip, flt;
        for (int i = NW - 1; i >= 0; i--)
            if (a >= m_base[i] && a <= m_lim[i]) c = m_cls[i];
        chk = (c >= 3'd1 && c <= 3'd4);
        cip = (c == 3'd2 || c == 3'd4);
        flt = (c >= 3'd5) || (w && (c == 3'd1 || c == 3'd2));
        return {w, chk && !flt, cip && !flt, chk && !flt, flt, chk && f && !w && !flt, 1'b0};
    endfunction

    task automatic issue(input logic [31:0] a, input logic w, input logic f, input string tag);
        exp_t e;
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_write = w; req_fetch = f;
        e.addr = a; e.flags = model(a, w, f); e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] l, input logic [2:0] c);
        @(posedge clk); #1;
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = 2'(i); cfg_base = b; cfg_limit = l; cfg_class = c;
        m_base[i] = b; m_lim[i] = l; m_cls[i] = c;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // monitor: compare registered results at the falling edge
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [6:0] got;
            exp_t e;
            got = {rsp_write, need_verify, need_crypt, to_engine, fault, code_ident, 1'b0};
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected response addr=%h", rsp_addr);
            end else begin
                e = sb.pop_front();
                if (got !== e.flags || rsp_addr !== e.addr) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual flags=%b addr=%h expected flags=%b",
                             e.tag, e.addr, got, rsp_addr, e.flags);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_base[i] = '1; m_lim[i] = '0; m_cls[i] = 3'd0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if ({rsp_valid, need_verify, need_crypt, to_engine, fault, code_ident} !== 6'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual=%b expected=0",
                     {rsp_valid, need_verify, need_crypt, to_engine, fault, code_ident});
        end
        #1 rst_n = 1'b1;

        // R2: empty table -> everything open
        issue(32'h0000_1000, 1'b0, 1'b1, "R2 empty table fetch");
        issue(32'hFFFF_FFFF, 1'b1, 1'b0, "R4 empty table store");
        idle();

        set_win(0, 32'h1000, 32'h1FFF, 3'd1);
        set_win(1, 32'h1800, 32'h2FFF, 3'd4);
        set_win(2, 32'h3000, 32'h3FFF, 3'd2);
        set_win(3, 32'h4000, 32'h40FF, 3'd6);

        issue(32'h0000_0FFF, 1'b0, 1'b0, "R4 below first window");
        issue(32'h0000_1000, 1'b0, 1'b1, "R2 R8 base fetch static checked");
        issue(32'h0000_1FFF, 1'b1, 1'b0, "R6 store at limit static checked");
        issue(32'h0000_1800, 1'b1, 1'b0, "R3 overlap lower index wins");
        issue(32'h0000_2000, 1'b1, 1'b0, "R5 R9 dynamic ciphered store");
        issue(32'h0000_2FFF, 1'b0, 1'b1, "R5 R8 dynamic ciphered fetch");
        issue(32'h0000_3000, 1'b0, 1'b0, "R5 static ciphered load");
        issue(32'h0000_3FFF, 1'b1, 1'b1, "R6 store static ciphered");
        issue(32'h0000_4000, 1'b0, 1'b0, "R7 illegal code load");
        issue(32'h0000_40FF, 1'b0, 1'b1, "R7 illegal code fetch");
        issue(32'h0000_4100, 1'b1, 1'b0, "R2 limit plus one open");
        idle();
        idle();

        // R10: write and lookup in the same clock -> old class
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_base = 32'h4000; cfg_limit = 32'h40FF; cfg_class = 3'd3;
        req_valid = 1'b1; req_addr = 32'h4010; req_write = 1'b0; req_fetch = 1'b1;
        begin
            exp_t e;
            e.addr = 32'h4010; e.flags = model(32'h4010, 1'b0, 1'b1); e.tag = "R10 same-cycle write sees old";
            sb.push_back(e);
        end
        m_cls[3] = 3'd3;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        req_valid = 1'b0;
        issue(32'h0000_4010, 1'b0, 1'b1, "R10 next cycle sees new class");
        issue(32'h0000_4020, 1'b1, 1'b0, "R5 dynamic checked store");
        idle();

        // R4: window programmed as open class
        set_win(0, 32'h1000, 32'h1FFF, 3'd0);
        issue(32'h0000_1800, 1'b1, 1'b1, "R4 R3 open window shadows lower priority");
        idle();
        repeat (3) @(posedge clk);

        n_run++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending responses actual=%0d expected=0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule